// File: doc/BRIEF.md
# Physical Register File Renamer

This block renames a group of up to four micro-ops per cycle, taken in program order. Logical registers are never storage; they are pointers into a single physical register file. A speculative alias table holds the newest mapping of each logical register. A retirement alias table holds the committed mapping. A bitmap of free physical tags supplies a fresh tag to every destination that needs one. For each destination the renamer reports the new tag and the tag it replaces. Source registers read the speculative table, and a source that an earlier op in the same group writes takes that op's new tag instead.

When an op retires, the retirement table is pointed at that op's tag and no data moves. The tag that the committed mapping held before becomes free again. Clearing idioms, such as XOR of a register with itself, are resolved during renaming: the destination is pointed at a reserved physical tag that always holds zero, and the op is reported complete at once. On a flush the speculative table is reloaded from the retirement table, and the free bitmap is rebuilt to hold every tag that the retirement table does not use. Data storage, scheduling and execution belong to other blocks.

Top module: `prf_renamer`

## Requirements
- R1: After reset every logical register maps to the reserved tag 0 in both tables, every source lookup returns 0, all tags 1 to NUM_PHYS-1 are free, and `renReady` is high.
- R2: A group is accepted when `renValid` and `renReady` are both high. Each lane with `laneValid`, `dstValid` and no `zeroIdiom` receives a distinct, nonzero, free tag. Tags are handed out lowest number first, in lane order (lane 0 first).
- R3: `oldTag` of a writing lane is the speculative mapping of its destination before this op. If an earlier lane of the same group writes that register, `oldTag` is that lane's new tag.
- R4: Each source tag is the speculative mapping of that source register. If one or more earlier lanes of the group write the register, the tag comes from the latest such lane.
- R5: A writing lane with `zeroIdiom` set gets `newTag` 0 and `doneNow` high, and takes no tag from the free bitmap. `doneNow` is low on all other lanes. Tag 0 is never handed out.
- R6: When the allocating lanes of a group outnumber the free tags, `renReady` is low, the group is not accepted, and no table or free-bitmap state changes because of it. A group is never accepted in part.
- R7: Each retiring lane (`retValid`, `retLog`, `retTag`) points the retirement mapping of `retLog` at `retTag`. The tag that mapping held before is freed unless it is 0. Retiring lanes are applied in lane order, lane 0 first.
- R8: While `flush` is high, `renReady` is low. After the edge, the speculative table equals the retirement table (including that cycle's retirements), and the free tags are exactly the nonzero tags that the retirement table does not reference.
- R9: A tag freed by retirement can be allocated from the next cycle on, not in the cycle it is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | A rename group is offered |
| laneValid | input | LANES | Lane holds an op |
| dstValid | input | LANES | Lane writes a logical register |
| zeroIdiom | input | LANES | Lane is a register-clearing idiom |
| dstLog | input | LANES*LW | Destination logical register per lane |
| src1Log | input | LANES*LW | First source logical register per lane |
| src2Log | input | LANES*LW | Second source logical register per lane |
| renReady | output | 1 | The group can be accepted this cycle |
| newTag | output | LANES*TW | New physical tag per lane |
| oldTag | output | LANES*TW | Replaced physical tag per lane |
| src1Tag | output | LANES*TW | Physical tag of first source |
| src2Tag | output | LANES*TW | Physical tag of second source |
| doneNow | output | LANES | Lane completes at rename (zeroing) |
| retValid | input | RET_LANES | Retiring op present per lane |
| retLog | input | RET_LANES*LW | Logical destination of retiring op |
| retTag | input | RET_LANES*TW | Physical tag of retiring op |
| flush | input | 1 | Discard speculative state |

## Verification
Groups with four distinct destinations and unrelated sources show allocation order and plain table lookup. Groups drawn from only two logical registers force chains of same-group writes, which separate correct bypass from lookup in the stale table and from picking the wrong earlier lane. Zero-heavy groups test that clearing ops consume no tags, and running without retirement drains the free bitmap to show whole-group stalls and freeing that takes effect one cycle late. Flushes taken with retirements in the same cycle, plus long random mixes, show whether the rebuilt free bitmap and tables stay consistent with a reference model that is checked every cycle.

// File: rtl/prf_ren_pkg.sv
package prf_ren_pkg;
  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic takeGroup;  // rename group accepted this cycle
    logic restore;    // reload speculative state from committed state
  } renStrobe_t;
endpackage

// File: rtl/prf_ren_ctrl.sv
module prf_ren_ctrl
  import prf_ren_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 5
) (
  input  logic             renValid,
  input  logic [LANES-1:0] laneValid,
  input  logic [LANES-1:0] dstValid,
  input  logic [LANES-1:0] zeroIdiom,
  input  logic             flush,
  input  logic [CW-1:0]    freeCount,
  output logic [LANES-1:0] allocMask,
  output logic [LANES-1:0] writeMask,
  output logic [LANES-1:0] doneNow,
  output logic [CW-1:0]    needCount,
  output logic             renReady,
  output renStrobe_t       strobe
);
  always_comb begin
    needCount = '0;
    for (int k = 0; k < LANES; k++) begin
      writeMask[k] = laneValid[k] && dstValid[k];
      allocMask[k] = writeMask[k] && !zeroIdiom[k];
      doneNow[k]   = writeMask[k] && zeroIdiom[k];
      needCount    = needCount + CW'(allocMask[k]);
    end
  end

  // whole group or nothing; flush cycles take no group
  assign renReady         = !flush && (needCount <= freeCount);
  assign strobe.takeGroup = renValid && renReady;
  assign strobe.restore   = flush;
endmodule

// File: rtl/prf_ren_dp.sv
module prf_ren_dp
  import prf_ren_pkg::*;
#(
  parameter int LANES = 4,
  parameter int RETW  = 4,
  parameter int NLOG  = 8,
  parameter int NPHYS = 24,
  parameter int LW    = 3,
  parameter int TW    = 5,
  parameter int CW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  renStrobe_t                strobe,
  input  logic [LANES-1:0]          allocMask,
  input  logic [LANES-1:0]          writeMask,
  input  logic [CW-1:0]             needCount,
  input  logic [LANES-1:0][LW-1:0]  dstLog,
  input  logic [LANES-1:0][LW-1:0]  src1Log,
  input  logic [LANES-1:0][LW-1:0]  src2Log,
  input  logic [RETW-1:0]           retValid,
  input  logic [RETW-1:0][LW-1:0]   retLog,
  input  logic [RETW-1:0][TW-1:0]   retTag,
  output logic [LANES-1:0][TW-1:0]  newTag,
  output logic [LANES-1:0][TW-1:0]  oldTag,
  output logic [LANES-1:0][TW-1:0]  src1Tag,
  output logic [LANES-1:0][TW-1:0]  src2Tag,
  output logic [CW-1:0]             freeCount
);
  logic [NLOG-1:0][TW-1:0] specMap, specNext;
  logic [NLOG-1:0][TW-1:0] archMap, archNext;
  logic [NPHYS-1:0]        freeMap, freeNext;
  logic [NPHYS-1:0]        pool;

  assign freeCount = CW'($countones(freeMap));

  // pick the lowest free tags, one per allocating lane in lane order
  always_comb begin
    pool = freeMap;
    for (int k = 0; k < LANES; k++) begin
      newTag[k] = '0;
      if (allocMask[k]) begin
        for (int p = NPHYS - 1; p >= 1; p--) begin
          if (pool[p]) newTag[k] = TW'(p);
        end
        pool[newTag[k]] = 1'b0;
      end
    end
  end

  // lookups with bypass from earlier lanes of the same group
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      src1Tag[k] = specMap[src1Log[k]];
      src2Tag[k] = specMap[src2Log[k]];
      oldTag[k]  = specMap[dstLog[k]];
      for (int j = 0; j < k; j++) begin
        if (writeMask[j]) begin
          if (dstLog[j] == src1Log[k]) src1Tag[k] = newTag[j];
          if (dstLog[j] == src2Log[k]) src2Tag[k] = newTag[j];
          if (dstLog[j] == dstLog[k])  oldTag[k]  = newTag[j];
        end
      end
    end
  end

  // next state: retirement, allocation, then flush rebuild
  always_comb begin
    specNext = specMap;
    archNext = archMap;
    freeNext = freeMap;
    for (int r = 0; r < RETW; r++) begin
      if (retValid[r]) begin
        if (archNext[retLog[r]] != '0) freeNext[archNext[retLog[r]]] = 1'b1;
        archNext[retLog[r]] = retTag[r];
      end
    end
    if (strobe.takeGroup) begin
      for (int k = 0; k < LANES; k++) begin
        if (writeMask[k]) specNext[dstLog[k]] = newTag[k];
        if (allocMask[k]) freeNext[newTag[k]] = 1'b0;
      end
    end
    if (strobe.restore) begin
      specNext    = archNext;
      freeNext    = '1;
      freeNext[0] = 1'b0;
      for (int i = 0; i < NLOG; i++) freeNext[archNext[i]] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      specMap    <= '0;
      archMap    <= '0;
      freeMap    <= '1;
      freeMap[0] <= 1'b0;
    end else begin
      specMap <= specNext;
      archMap <= archNext;
      freeMap <= freeNext;
    end
  end

  // ---------------- assertions ----------------
  AST_ZERO_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    freeMap[0] == 1'b0);  // R5

  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeGroup && !strobe.restore && (retValid == '0)
    |=> freeCount == $past(freeCount) - $past(needCount));  // R6

  AST_RETIRE_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    retValid[RETW-1] |=> archMap[$past(retLog[RETW-1])] == $past(retTag[RETW-1]));  // R7

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.takeGroup && allocMask[k] |-> freeMap[newTag[k]] && (newTag[k] != '0));  // R2
    for (genvar j = 0; j < k; j++) begin : g_pair
      AST_ALLOC_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.takeGroup && allocMask[k] && allocMask[j] |-> newTag[k] != newTag[j]);  // R2
    end
  end

  for (genvar i = 0; i < NLOG; i++) begin : g_map_chk
    AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.restore |=> specMap[i] == archMap[i]);  // R8
  end
endmodule

// File: rtl/prf_renamer.sv
module prf_renamer
  import prf_ren_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int RET_LANES = 4,
  parameter int NUM_LOG   = 8,
  parameter int NUM_PHYS  = 24,
  localparam int LW = $clog2(NUM_LOG),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    renValid,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES-1:0]        dstValid,
  input  logic [LANES-1:0]        zeroIdiom,
  input  logic [LANES*LW-1:0]     dstLog,
  input  logic [LANES*LW-1:0]     src1Log,
  input  logic [LANES*LW-1:0]     src2Log,
  output logic                    renReady,
  output logic [LANES*TW-1:0]     newTag,
  output logic [LANES*TW-1:0]     oldTag,
  output logic [LANES*TW-1:0]     src1Tag,
  output logic [LANES*TW-1:0]     src2Tag,
  output logic [LANES-1:0]        doneNow,
  input  logic [RET_LANES-1:0]    retValid,
  input  logic [RET_LANES*LW-1:0] retLog,
  input  logic [RET_LANES*TW-1:0] retTag,
  input  logic                    flush
);
  renStrobe_t                strobe;
  logic [LANES-1:0]          allocMask, writeMask;
  logic [CW-1:0]             needCount, freeCount;
  logic [LANES-1:0][LW-1:0]  dstLogV, src1LogV, src2LogV;
  logic [LANES-1:0][TW-1:0]  newTagV, oldTagV, src1TagV, src2TagV;
  logic [RET_LANES-1:0][LW-1:0] retLogV;
  logic [RET_LANES-1:0][TW-1:0] retTagV;

  assign dstLogV  = dstLog;
  assign src1LogV = src1Log;
  assign src2LogV = src2Log;
  assign retLogV  = retLog;
  assign retTagV  = retTag;
  assign newTag   = newTagV;
  assign oldTag   = oldTagV;
  assign src1Tag  = src1TagV;
  assign src2Tag  = src2TagV;

  prf_ren_ctrl #(.LANES(LANES), .CW(CW)) u_ctrl (
    .renValid  (renValid),
    .laneValid (laneValid),
    .dstValid  (dstValid),
    .zeroIdiom (zeroIdiom),
    .flush     (flush),
    .freeCount (freeCount),
    .allocMask (allocMask),
    .writeMask (writeMask),
    .doneNow   (doneNow),
    .needCount (needCount),
    .renReady  (renReady),
    .strobe    (strobe)
  );

  prf_ren_dp #(
    .LANES(LANES), .RETW(RET_LANES), .NLOG(NUM_LOG), .NPHYS(NUM_PHYS),
    .LW(LW), .TW(TW), .CW(CW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .allocMask (allocMask),
    .writeMask (writeMask),
    .needCount (needCount),
    .dstLog    (dstLogV),
    .src1Log   (src1LogV),
    .src2Log   (src2LogV),
    .retValid  (retValid),
    .retLog    (retLogV),
    .retTag    (retTagV),
    .newTag    (newTagV),
    .oldTag    (oldTagV),
    .src1Tag   (src1TagV),
    .src2Tag   (src2TagV),
    .freeCount (freeCount)
  );
endmodule

// File: tb/prf_renamer_tb.sv
`timescale 1ns/100ps
module prf_renamer_tb;
  localparam int L  = 4;
  localparam int RW = 4;
  localparam int NL = 8;
  localparam int NP = 24;
  localparam int LW = 3;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic renValid;
  logic [L-1:0] laneValid, dstValid, zeroIdiom, doneNow;
  logic [L*LW-1:0] dstLog, src1Log, src2Log;
  logic renReady;
  logic [L*TW-1:0] newTag, oldTag, src1Tag, src2Tag;
  logic [RW-1:0] retValid;
  logic [RW*LW-1:0] retLog;
  logic [RW*TW-1:0] retTag;
  logic flush;

  always #2.5 clk = ~clk;

  prf_renamer u_dut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .laneValid(laneValid),
    .dstValid(dstValid), .zeroIdiom(zeroIdiom), .dstLog(dstLog),
    .src1Log(src1Log), .src2Log(src2Log), .renReady(renReady),
    .newTag(newTag), .oldTag(oldTag), .src1Tag(src1Tag), .src2Tag(src2Tag),
    .doneNow(doneNow), .retValid(retValid), .retLog(retLog),
    .retTag(retTag), .flush(flush)
  );

  // reference model state
  int mSpec[NL];
  int mArch[NL];
  bit mFree[NP];
  int qLog[$];
  int qTag[$];

  // stimulus for the next group
  bit grpValid;
  bit laneV[L], dstV[L], zI[L];
  int dL[L], s1L[L], s2L[L];

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";
  int rot = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (%s phase) %s: got %0d expected %0d", req, curReq, what, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NL; i++) begin mSpec[i] = 0; mArch[i] = 0; end
    for (int p = 0; p < NP; p++) mFree[p] = (p != 0);
    qLog.delete(); qTag.delete();
  endtask

  // one cycle: drive, compare at mid-cycle, advance the model
  task automatic step(input int nRetReq, input bit doFlush);
    int nRet, need, freeCnt, t, o, l;
    int expNew[L];
    bit alloc[L];
    bit pool[NP];
    bit take;
    nRet = (nRetReq < qLog.size()) ? nRetReq : qLog.size();
    renValid = grpValid;
    for (int k = 0; k < L; k++) begin
      laneValid[k] = laneV[k];
      dstValid[k]  = dstV[k];
      zeroIdiom[k] = zI[k];
      dstLog[k*LW +: LW]  = LW'(dL[k]);
      src1Log[k*LW +: LW] = LW'(s1L[k]);
      src2Log[k*LW +: LW] = LW'(s2L[k]);
    end
    for (int r = 0; r < RW; r++) begin
      retValid[r] = (r < nRet);
      retLog[r*LW +: LW] = (r < nRet) ? LW'(qLog[r]) : '0;
      retTag[r*TW +: TW] = (r < nRet) ? TW'(qTag[r]) : '0;
    end
    flush = doFlush;
    #1;
    need = 0; freeCnt = 0;
    for (int k = 0; k < L; k++) begin
      alloc[k] = laneV[k] && dstV[k] && !zI[k];
      need += int'(alloc[k]);
    end
    for (int p = 0; p < NP; p++) freeCnt += int'(mFree[p]);
    take = grpValid && !doFlush && (need <= freeCnt);
    chk(renReady == (!doFlush && (need <= freeCnt)), "R6", "renReady",
        int'(renReady), int'(!doFlush && (need <= freeCnt)));
    for (int p = 0; p < NP; p++) pool[p] = mFree[p];
    for (int k = 0; k < L; k++) begin
      expNew[k] = 0;
      if (alloc[k]) begin
        for (int p = NP - 1; p >= 1; p--) if (pool[p]) expNew[k] = p;
        pool[expNew[k]] = 1'b0;
      end
    end
    if (take) begin
      for (int k = 0; k < L; k++) begin
        if (!laneV[k]) continue;
        t = mSpec[s1L[k]];
        for (int j = 0; j < k; j++) if (laneV[j] && dstV[j] && dL[j] == s1L[k]) t = expNew[j];
        chk(int'(src1Tag[k*TW +: TW]) == t, "R4", $sformatf("lane%0d src1Tag", k),
            int'(src1Tag[k*TW +: TW]), t);
        t = mSpec[s2L[k]];
        for (int j = 0; j < k; j++) if (laneV[j] && dstV[j] && dL[j] == s2L[k]) t = expNew[j];
        chk(int'(src2Tag[k*TW +: TW]) == t, "R4", $sformatf("lane%0d src2Tag", k),
            int'(src2Tag[k*TW +: TW]), t);
        chk(doneNow[k] == (dstV[k] && zI[k]), "R5", $sformatf("lane%0d doneNow", k),
            int'(doneNow[k]), int'(dstV[k] && zI[k]));
        if (dstV[k]) begin
          o = mSpec[dL[k]];
          for (int j = 0; j < k; j++) if (laneV[j] && dstV[j] && dL[j] == dL[k]) o = expNew[j];
          chk(int'(oldTag[k*TW +: TW]) == o, "R3", $sformatf("lane%0d oldTag", k),
              int'(oldTag[k*TW +: TW]), o);
          chk(int'(newTag[k*TW +: TW]) == expNew[k], zI[k] ? "R5" : "R2",
              $sformatf("lane%0d newTag", k), int'(newTag[k*TW +: TW]), expNew[k]);
        end
      end
    end
    // advance model: retire (lane order), accept group, flush
    for (int r = 0; r < nRet; r++) begin
      l = qLog.pop_front();
      t = qTag.pop_front();
      if (mArch[l] != 0) mFree[mArch[l]] = 1'b1;
      mArch[l] = t;
    end
    if (take) begin
      for (int k = 0; k < L; k++) begin
        if (laneV[k] && dstV[k]) begin
          mSpec[dL[k]] = expNew[k];
          if (alloc[k]) mFree[expNew[k]] = 1'b0;
          qLog.push_back(dL[k]);
          qTag.push_back(expNew[k]);
        end
      end
    end
    if (doFlush) begin
      for (int p = 0; p < NP; p++) mFree[p] = (p != 0);
      for (int i = 0; i < NL; i++) begin
        mSpec[i] = mArch[i];
        mFree[mArch[i]] = 1'b0;
      end
      qLog.delete(); qTag.delete();
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // mode 0 random, 1 distinct dsts, 2 two-register overlap, 3 zero-heavy
  task automatic gen(input int mode);
    grpValid = 1'b1;
    rot = (rot + 3) % NL;
    for (int k = 0; k < L; k++) begin
      laneV[k] = (mode == 1) ? 1'b1 : ($urandom_range(0, 3) != 0);
      dstV[k]  = (mode == 1) ? 1'b1 : ($urandom_range(0, 3) != 0);
      zI[k]    = (mode == 3) ? ($urandom_range(0, 1) != 0)
               : (mode == 0) ? ($urandom_range(0, 7) == 0) : 1'b0;
      if (mode == 2) begin
        dL[k]  = int'($urandom_range(0, 1));
        s1L[k] = int'($urandom_range(0, 1));
        s2L[k] = int'($urandom_range(0, 1));
      end else if (mode == 1) begin
        dL[k]  = (rot + k) % NL;
        s1L[k] = (rot + k + 4) % NL;
        s2L[k] = (rot + 7 * k + 1) % NL;
      end else begin
        dL[k]  = int'($urandom_range(0, NL - 1));
        s1L[k] = int'($urandom_range(0, NL - 1));
        s2L[k] = int'($urandom_range(0, NL - 1));
      end
    end
  endtask

  task automatic oneAlloc();
    grpValid = 1'b1;
    for (int k = 0; k < L; k++) begin
      laneV[k] = (k == 0); dstV[k] = (k == 0); zI[k] = 1'b0;
      dL[k] = 5; s1L[k] = 5; s2L[k] = 2;
    end
  endtask

  task automatic idle();
    grpValid = 1'b0;
    for (int k = 0; k < L; k++) begin
      laneV[k] = 0; dstV[k] = 0; zI[k] = 0; dL[k] = k; s1L[k] = k; s2L[k] = k + 4;
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog (%s phase): got %0d cycles expected fewer", curReq, cycles);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    flush = 1'b0;
    renValid = 1'b0;
    laneValid = '0; dstValid = '0; zeroIdiom = '0;
    dstLog = '0; src1Log = '0; src2Log = '0;
    retValid = '0; retLog = '0; retTag = '0;
    idle();
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every lookup returns tag 0
    curReq = "R1";
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < L; k++) begin
        src1Log[k*LW +: LW] = LW'(k + 4 * pass);
        src2Log[k*LW +: LW] = LW'(7 - k - 4 * pass);
      end
      #1;
      for (int k = 0; k < L; k++) begin
        chk(src1Tag[k*TW +: TW] == '0, "R1", "reset src1Tag", int'(src1Tag[k*TW +: TW]), 0);
        chk(src2Tag[k*TW +: TW] == '0, "R1", "reset src2Tag", int'(src2Tag[k*TW +: TW]), 0);
      end
      chk(renReady == 1'b1, "R1", "reset renReady", int'(renReady), 1);
      @(negedge clk);
    end

    // R2: full groups of distinct destinations, tags 1..4 first
    curReq = "R2";
    for (int n = 0; n < 3; n++) begin gen(1); step(0, 0); end
    // R3/R4: same-group writes chained through two registers
    curReq = "R3";
    for (int n = 0; n < 20; n++) begin gen(2); step(4, 0); end
    curReq = "R4";
    for (int n = 0; n < 20; n++) begin gen(2); step(3, 0); end
    // R5: zeroing idioms
    curReq = "R5";
    for (int n = 0; n < 30; n++) begin gen(3); step(4, 0); end
    // R6: drain the free bitmap with no retirement, then hold a stalled group
    curReq = "R6";
    for (int n = 0; n < 12; n++) begin gen(1); step(0, 0); end
    // R9: with the bitmap drained, retire one op per cycle and request one tag
    curReq = "R9";
    for (int n = 0; n < 30; n++) begin oneAlloc(); step(1, 0); end
    // R7: retirement drains the in-flight queue
    curReq = "R7";
    for (int n = 0; n < 20; n++) begin gen(0); step(4, 0); end
    idle();
    for (int n = 0; n < 10; n++) step(4, 0);
    // R8: flush with and without same-cycle retirement
    curReq = "R8";
    for (int n = 0; n < 6; n++) begin gen(0); step(1, 0); end
    gen(1); step(2, 1);
    for (int n = 0; n < 4; n++) begin gen(2); step(0, 0); end
    gen(0); step(0, 1);
    gen(1); step(0, 0);
    // random mix
    curReq = "R2";
    for (int n = 0; n < 3000; n++) begin
      int m, nr;
      m = int'($urandom_range(0, 3));
      nr = int'($urandom_range(0, 4));
      if ($urandom_range(0, 4) == 0) idle(); else gen(m);
      step(nr, $urandom_range(0, 60) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule